// File: doc/BRIEF.md
# Acknowledge Status Register Bank

This block holds the completion record that a privileged function keeps for the messages it has sent to its subordinate functions. Each subordinate function ID owns one bit. When the mailbox core reports that subordinate N has issued its receive command, the bit for N is set. In the same cycle the block signals that the outgoing-message flag for target N should drop. The bits are grouped into 32-bit words. A driver can therefore collect several completions with a single register read and clear them by writing the value it read back to the same word.

A one-bit summary in a status register reads 1 whenever any acknowledge bit is set. Software can poll that bit alone, or read the words only once it sees work pending. The bank is sized by the `NUM_FUNCS` parameter, with a default of 64 functions held in two words. Receive events come in on a strobe carrying the function ID. Register accesses use a simple address, write-enable and data port, with a combinational read result.

Top module: `ack_status_bank`

## Requirements
- R1: After reset every acknowledge bit is 0, `ackAny` is 0 and the status register reads 0.
- R2: A receive event for function N (N < NUM_FUNCS) sets bit N mod 32 of acknowledge word N/32. The bit is visible on `ackBits[N]` and on register reads from the cycle after the event.
- R3: Acknowledge word k is read at address ACK_BASE + k, with a default ACK_BASE of 0x22420. Bit positions at or above NUM_FUNCS read as 0.
- R4: The status register at STATUS_ADDR (default 0x22400) returns the OR of all acknowledge bits in bit 0 and zeros in bits 31:1. `ackAny` carries the same value.
- R5: A write to acknowledge word k clears, from the next cycle, every bit written as 1. Bits written as 0 keep their value (write-1-to-clear).
- R6: When a receive event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R7: Several bits set by separate events are all reported together by one read of their word.
- R8: A write to the status register or to any unmapped address leaves every acknowledge bit unchanged. A read of an unmapped address returns 0.
- R9: In the cycle a receive event for N is presented, `outClrVld` is 1 and `outClrFn` equals N. Otherwise `outClrVld` is 0.
- R10: A receive event or a clearing write changes no bit other than the bits it targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rcvVld | input | 1 | Receive-command event strobe from the mailbox core |
| rcvFn | input | FN_W | Function ID of the subordinate that received |
| regAddr | input | ADDR_W | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| ackBits | output | NUM_FUNCS | Current acknowledge bits, one per function |
| ackAny | output | 1 | Summary: any acknowledge bit set |
| outClrVld | output | 1 | Request to clear the outgoing-message flag |
| outClrFn | output | FN_W | Target whose outgoing flag is cleared |

## Verification
The bench walks every function ID on its own. For each ID it sets the bit, then reads both words and the status register, then clears the bit and reads again. This separates wrong word selection, wrong bit position and leakage into neighbouring bits. A second pattern sets a spread of IDs across both words and clears them with partial masks. This shows that one read returns many completions and that zero bits in a write have no effect. Collision cycles, in which an event and a clearing write target the same bit, tell set-wins apart from clear-wins. Writes to the status register and to unmapped addresses show that these accesses are ignored.

// File: rtl/ack_pkg.sv
package ack_pkg;
  parameter int WORD_W   = 32;
  parameter int MAX_FN_W = 8;

  typedef struct packed {
    logic                setVld;
    logic [MAX_FN_W-1:0] setFn;
    logic                clrVld;
    logic [MAX_FN_W-1:0] clrWord;
    logic [WORD_W-1:0]   clrMask;
  } ackStrobeT;
endpackage

// File: rtl/ack_ctrl.sv
module ack_ctrl
  import ack_pkg::*;
#(
  parameter int NUM_FUNCS   = 64,
  parameter int FN_W        = 6,
  parameter int ADDR_W      = 18,
  parameter int ACK_BASE    = 'h22420,
  parameter int STATUS_ADDR = 'h22400,
  localparam int NUM_WORDS  = (NUM_FUNCS + WORD_W - 1) / WORD_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rcvVld,
  input  logic [FN_W-1:0]             rcvFn,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic                        regWrEn,
  input  logic [WORD_W-1:0]           regWrData,
  input  logic [NUM_WORDS*WORD_W-1:0] bankWords,
  output ackStrobeT                   strobe,
  output logic [WORD_W-1:0]           regRdData,
  output logic                        ackAny,
  output logic                        outClrVld,
  output logic [FN_W-1:0]             outClrFn
);
  localparam logic [ADDR_W-1:0] ACK_BASE_A = ADDR_W'(ACK_BASE);
  localparam logic [ADDR_W-1:0] STATUS_A   = ADDR_W'(STATUS_ADDR);

  logic [ADDR_W-1:0] wordOff;
  logic              ackHit;
  logic              statusHit;
  logic              fnInRange;

  assign wordOff   = regAddr - ACK_BASE_A;
  assign ackHit    = (regAddr >= ACK_BASE_A) && (wordOff < ADDR_W'(NUM_WORDS));
  assign statusHit = (regAddr == STATUS_A);
  assign fnInRange = (int'(rcvFn) < NUM_FUNCS);
  assign ackAny    = |bankWords;

  always_comb begin
    strobe         = '0;
    strobe.setVld  = rcvVld && fnInRange;
    strobe.setFn   = MAX_FN_W'(rcvFn);
    strobe.clrVld  = regWrEn && ackHit;
    strobe.clrWord = MAX_FN_W'(wordOff);
    strobe.clrMask = regWrData;
  end

  always_comb begin
    regRdData = '0;
    if (statusHit) begin
      regRdData[0] = ackAny;
    end else if (ackHit) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (int'(wordOff) == w) regRdData = bankWords[w*WORD_W +: WORD_W];
      end
    end
  end

  assign outClrVld = rcvVld && fnInRange;
  assign outClrFn  = rcvFn;

  // R4
  ack_any_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackAny) |-> $past(rcvVld));

  // R9
  out_clr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outClrVld |-> (int'(outClrFn) < NUM_FUNCS));
endmodule

// File: rtl/ack_datapath.sv
module ack_datapath
  import ack_pkg::*;
#(
  parameter int NUM_FUNCS  = 64,
  localparam int NUM_WORDS = (NUM_FUNCS + WORD_W - 1) / WORD_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ackStrobeT                   strobe,
  output logic [NUM_WORDS*WORD_W-1:0] bankWords
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int LIVE = (NUM_FUNCS - w*WORD_W) >= WORD_W ? WORD_W
                                                            : NUM_FUNCS - w*WORD_W;
    localparam logic [WORD_W-1:0] LIVE_MASK = (LIVE == WORD_W) ? '1
                                            : WORD_W'((64'd1 << LIVE) - 64'd1);
    logic [WORD_W-1:0] setMask;
    logic [WORD_W-1:0] clrMask;
    logic [WORD_W-1:0] cur;

    always_comb begin
      setMask = '0;
      if (strobe.setVld && (int'(strobe.setFn) / WORD_W == w))
        setMask[strobe.setFn[4:0]] = 1'b1;
      clrMask = (strobe.clrVld && (int'(strobe.clrWord) == w)) ? strobe.clrMask : '0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cur <= '0;
      else       cur <= ((cur & ~clrMask) | setMask) & LIVE_MASK;
    end

    assign bankWords[w*WORD_W +: WORD_W] = cur;
  end

  // R2 R6
  set_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setVld |=> bankWords[$past(strobe.setFn)]);

  for (genvar b = 0; b < NUM_FUNCS; b++) begin : g_bit
    // R10
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!(strobe.setVld && int'(strobe.setFn) == b) &&
       !(strobe.clrVld && int'(strobe.clrWord) == b / WORD_W && strobe.clrMask[b % WORD_W]))
      |=> $stable(bankWords[b]));
    // R5
    bit_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clrVld && int'(strobe.clrWord) == b / WORD_W && strobe.clrMask[b % WORD_W] &&
       !(strobe.setVld && int'(strobe.setFn) == b))
      |=> !bankWords[b]);
  end
endmodule

// File: rtl/ack_status_bank.sv
module ack_status_bank
  import ack_pkg::*;
#(
  parameter int NUM_FUNCS   = 64,
  parameter int FN_W        = 6,
  parameter int ADDR_W      = 18,
  parameter int ACK_BASE    = 'h22420,
  parameter int STATUS_ADDR = 'h22400
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rcvVld,
  input  logic [FN_W-1:0]      rcvFn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic [NUM_FUNCS-1:0] ackBits,
  output logic                 ackAny,
  output logic                 outClrVld,
  output logic [FN_W-1:0]      outClrFn
);
  localparam int NUM_WORDS = (NUM_FUNCS + WORD_W - 1) / WORD_W;

  ackStrobeT                   strobe;
  logic [NUM_WORDS*WORD_W-1:0] bankWords;

  ack_ctrl #(
    .NUM_FUNCS(NUM_FUNCS), .FN_W(FN_W), .ADDR_W(ADDR_W),
    .ACK_BASE(ACK_BASE), .STATUS_ADDR(STATUS_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rcvVld(rcvVld), .rcvFn(rcvFn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .bankWords(bankWords), .strobe(strobe), .regRdData(regRdData),
    .ackAny(ackAny), .outClrVld(outClrVld), .outClrFn(outClrFn)
  );

  ack_datapath #(.NUM_FUNCS(NUM_FUNCS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bankWords(bankWords)
  );

  assign ackBits = bankWords[NUM_FUNCS-1:0];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (ackBits == '0));
endmodule

// File: tb/ack_status_bank_bench.sv
module ack_status_bank_bench;
  localparam int NF = 64;
  localparam logic [17:0] BASE = 18'h22420;
  localparam logic [17:0] STAT = 18'h22400;

  logic        clk = 0;
  logic        rstN = 0;
  logic        rcvVld = 0;
  logic [5:0]  rcvFn = '0;
  logic [17:0] regAddr = '0;
  logic        regWrEn = 0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NF-1:0] ackBits;
  logic        ackAny;
  logic        outClrVld;
  logic [5:0]  outClrFn;

  int compared = 0;
  int mismatched = 0;
  logic [NF-1:0] model = '0;
  bit done = 0;

  always #10 clk = ~clk;

  ack_status_bank u_ack_status_bank (
    .clk(clk), .rstN(rstN), .rcvVld(rcvVld), .rcvFn(rcvFn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .ackBits(ackBits), .ackAny(ackAny),
    .outClrVld(outClrVld), .outClrFn(outClrFn)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readAt(logic [17:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic checkAll(string req);
    logic [31:0] d;
    check({req, " bits"}, 64'(ackBits), 64'(model));
    check({req, " any"}, 64'(ackAny), 64'(|model));
    readAt(BASE, d);        check({req, " word0 R3"}, 64'(d), 64'(model[31:0]));
    readAt(BASE + 18'd1, d); check({req, " word1 R3"}, 64'(d), 64'(model[63:32]));
    readAt(STAT, d);        check({req, " status R4"}, 64'(d), 64'({31'b0, |model}));
  endtask

  task automatic event_(int fn);
    @(negedge clk);
    rcvVld = 1; rcvFn = 6'(fn);
    #1;
    check("R9 clr vld", 64'(outClrVld), 64'd1);
    check("R9 clr fn", 64'(outClrFn), 64'(fn));
    @(negedge clk);
    rcvVld = 0;
    model[fn] = 1'b1;
  endtask

  task automatic write_(logic [17:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrEn = 1; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
    if (a == BASE) model[31:0] = model[31:0] & ~d;
    else if (a == BASE + 18'd1) model[63:32] = model[63:32] & ~d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1 check("R9 idle", 64'(outClrVld), 64'd0);
    checkAll("R1 reset");

    // R2 R10: single-bit sweep over every function
    for (int n = 0; n < NF; n++) begin
      event_(n);
      checkAll("R2 sweep set");
      write_(BASE + 18'(n / 32), 32'd1 << (n % 32));
      checkAll("R5 sweep clear");
    end

    // R7: multiple completions in one read
    for (int n = 0; n < NF; n += 7) event_(n);
    event_(31); event_(32); event_(63);
    checkAll("R7 multi");

    // R5: partial write-1-to-clear, zero bits keep value
    write_(BASE, 32'h0000_FF0F);
    checkAll("R5 partial w0");
    write_(BASE + 18'd1, 32'hAAAA_5555);
    checkAll("R5 partial w1");

    // R8: writes to status / unmapped do nothing; unmapped reads zero
    write_(STAT, 32'hFFFF_FFFF);
    write_(BASE + 18'd2, 32'hFFFF_FFFF);
    write_(BASE - 18'd1, 32'hFFFF_FFFF);
    checkAll("R8 ignored writes");
    begin
      logic [31:0] d;
      readAt(BASE + 18'd2, d); check("R8 unmapped read", 64'(d), 64'd0);
      readAt(18'h0, d);        check("R8 unmapped read 0", 64'(d), 64'd0);
    end

    // R6: set and clear on same bit, same cycle
    foreach (model[i]) if (1) ;
    write_(BASE, 32'hFFFF_FFFF);
    write_(BASE + 18'd1, 32'hFFFF_FFFF);
    checkAll("R5 full clear");
    for (int n = 0; n < NF; n += 13) begin
      @(negedge clk);
      rcvVld = 1; rcvFn = 6'(n);
      regAddr = BASE + 18'(n / 32); regWrEn = 1; regWrData = 32'hFFFF_FFFF;
      @(negedge clk);
      rcvVld = 0; regWrEn = 0;
      model = '0;
      model[n] = 1'b1;
      checkAll("R6 set wins");
      write_(BASE + 18'(n / 32), 32'd1 << (n % 32));
    end
    checkAll("R1 final empty");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule